// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial frame. A character is written into a one-entry holding register with a valid strobe. As soon as the shift stage is free the character moves into it. It then leaves on the line as a low start bit, then the data bits with the least significant first, then an optional parity bit, then the stop period. The line rests high between frames. Bit timing comes from an external tick that runs at sixteen times the bit rate, so one bit spans sixteen ticks.

The frame shape is taken from a small set of line-control inputs: word length, stop select, parity enable, even select, stick parity and break. The first five are captured when a character enters the shift stage, so a frame already on the line keeps its shape. Break acts at once and holds the line low while it is asserted. Two flags tell the writer whether the holding register can take a character and whether the whole transmitter has drained.

Top module: `async_char_tx`

## Requirements
- R1: After reset, and whenever the transmitter is drained with break low, `txLine` is high (mark), and `holdEmpty` and `txEmpty` are both 1.
- R2: A frame starts with one low start bit, followed by the data bits least significant first. Each start, data and parity bit lasts `TICKS_PER_BIT` (16) ticks of `baudTick`. `txLine` changes only in the cycle after a tick, on the cycle a character is loaded, or when break changes.
- R3: `wordLen` selects the number of data bits: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Bits of `wrData` above the word length are not sent.
- R4: With `stopSel`=0 the stop period is 16 ticks. With `stopSel`=1 it is 24 ticks for 5-bit words and 32 ticks for 6-, 7- and 8-bit words. The stop level is high.
- R5: With `parityEn`=1 a parity bit follows the last data bit. With `evenSel`=1 it is the XOR of the sent data bits (even parity); with `evenSel`=0 it is the inverse (odd parity). With `parityEn`=0 no parity bit is sent.
- R6: With `parityEn`=1 and `stickPar`=1 the parity bit is the inverse of `evenSel` (0 when `evenSel`=1, 1 when `evenSel`=0), whatever the data.
- R7: While `breakCtl` is 1, `txLine` is 0. Frame timing carries on underneath, and the line shows the frame again as soon as break drops.
- R8: A write (`wrValid`=1) is accepted only when `holdEmpty` is 1. `holdEmpty` falls in the cycle after an accepted write and rises in the cycle after the character moves to the shift stage. A write while `holdEmpty` is 0 is ignored and never reaches the line.
- R9: `txEmpty` is 1 only when the holding register is empty and no frame is in progress.
- R10: A character that is waiting in the holding register is loaded on the same clock edge that ends the previous stop period, so its start bit follows with no idle cycle in between.
- R11: Word length, stop select, parity enable, even select and stick parity are sampled when a character is loaded. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baudTick | input | 1 | One-cycle pulse at sixteen times the bit rate |
| wrData | input | 8 | Character to send |
| wrValid | input | 1 | Write strobe for the holding register |
| wordLen | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| stopSel | input | 1 | Long stop period when 1 |
| parityEn | input | 1 | Append a parity bit when 1 |
| evenSel | input | 1 | Even parity when 1, odd when 0 |
| stickPar | input | 1 | Force the parity bit to the inverse of evenSel |
| breakCtl | input | 1 | Hold the line low while 1 |
| txLine | output | 1 | Serial output, idles high |
| holdEmpty | output | 1 | Holding register can take a character |
| txEmpty | output | 1 | Holding register and shift stage both empty |

## Verification
The assertions check the properties that hold at every cycle. The flags must agree with each other. Break must hold the line low. A drained transmitter must show mark. A fall of `holdEmpty` must follow a write. The line may change only after a tick, on a load, or with break, and a load must put a start bit on the line. Only the bench's scenarios show the frame contents: bit order, parity values under each parity mode, the tick length of every stop setting, word-length masking, that ignored writes never appear, gapless back-to-back loading, and that settings are captured at load. Each scenario runs against a frame-list reference model that is compared with the outputs on every clock.

// File: rtl/async_char_tx_pkg.sv
package async_char_tx_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txState_e;

  typedef enum logic [1:0] {
    DRV_MARK,
    DRV_SPACE,
    DRV_DATA,
    DRV_PARITY
  } lineDrive_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadShift;
    logic       advBit;
    logic       busy;
    logic       inStop;
    lineDrive_e drive;
  } txCtrl_t;

  // line settings captured at load
  typedef struct packed {
    logic [1:0] wordLen;
    logic       stopSel;
    logic       parityEn;
    logic       evenSel;
    logic       stickPar;
  } frameCfg_t;

endpackage

// File: rtl/async_char_tx_ctrl.sv
module async_char_tx_ctrl
  import async_char_tx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    holdFull,
  input  logic    bitEnd,
  input  logic    lastData,
  input  logic    parOn,
  output txCtrl_t ctl,
  output logic    shiftIdle
);

  txState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext     = state;
    ctl.loadShift = 1'b0;
    ctl.advBit    = 1'b0;
    ctl.busy      = 1'b1;
    ctl.inStop    = 1'b0;
    ctl.drive     = DRV_MARK;
    unique case (state)
      ST_IDLE: begin
        ctl.busy = 1'b0;
        if (holdFull) begin
          ctl.loadShift = 1'b1;
          stateNext     = ST_START;
        end
      end
      ST_START: begin
        ctl.drive = DRV_SPACE;
        if (bitEnd) stateNext = ST_DATA;
      end
      ST_DATA: begin
        ctl.drive = DRV_DATA;
        if (bitEnd) begin
          ctl.advBit = 1'b1;
          if (lastData) stateNext = parOn ? ST_PARITY : ST_STOP;
        end
      end
      ST_PARITY: begin
        ctl.drive = DRV_PARITY;
        if (bitEnd) stateNext = ST_STOP;
      end
      ST_STOP: begin
        ctl.inStop = 1'b1;
        if (bitEnd) begin
          if (holdFull) begin
            ctl.loadShift = 1'b1;
            stateNext     = ST_START;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign shiftIdle = (state == ST_IDLE);

endmodule

// File: rtl/async_char_tx_dp.sv
module async_char_tx_dp
  import async_char_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrValid,
  input  frameCfg_t         cfgIn,
  input  logic              breakCtl,
  input  txCtrl_t           ctl,
  output logic              holdFull,
  output logic              bitEnd,
  output logic              lastData,
  output logic              parOn,
  output logic              txLine
);

  localparam int CNT_W = $clog2(2 * TICKS_PER_BIT);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_ONE  = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] LAST_HALF = CNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_TWO  = CNT_W'(2 * TICKS_PER_BIT - 1);

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] dataMask;
  logic [DATA_W-1:0] maskedHold;
  logic [CNT_W-1:0]  tickCnt;
  logic [CNT_W-1:0]  lastTick;
  logic [BIT_W-1:0]  bitCnt;
  frameCfg_t         latCfg;
  logic              parBit;
  logic              parNext;
  logic              lineRaw;

  // holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      holdReg  <= '0;
    end else if (ctl.loadShift) begin
      holdFull <= 1'b0;
    end else if (wrValid && !holdFull) begin
      holdFull <= 1'b1;
      holdReg  <= wrData;
    end
  end

  // parity of the masked character
  assign dataMask   = {DATA_W{1'b1}} >> (2'd3 - cfgIn.wordLen);
  assign maskedHold = holdReg & dataMask;

  always_comb begin
    if (cfgIn.stickPar)     parNext = ~cfgIn.evenSel;
    else if (cfgIn.evenSel) parNext = ^maskedHold;
    else                    parNext = ~^maskedHold;
  end

  // shift stage and settings captured at load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      latCfg   <= '0;
      parBit   <= 1'b0;
      bitCnt   <= '0;
    end else if (ctl.loadShift) begin
      shiftReg <= maskedHold;
      latCfg   <= cfgIn;
      parBit   <= parNext;
      bitCnt   <= '0;
    end else if (ctl.advBit) begin
      shiftReg <= shiftReg >> 1;
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  // stop length from the captured settings
  always_comb begin
    if (!ctl.inStop)                   lastTick = LAST_ONE;
    else if (!latCfg.stopSel)          lastTick = LAST_ONE;
    else if (latCfg.wordLen == 2'b00)  lastTick = LAST_HALF;
    else                               lastTick = LAST_TWO;
  end

  assign bitEnd = ctl.busy && baudTick && (tickCnt == lastTick);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     tickCnt <= '0;
    else if (ctl.loadShift)        tickCnt <= '0;
    else if (ctl.busy && baudTick) tickCnt <= bitEnd ? '0 : tickCnt + 1'b1;
  end

  assign lastData = (bitCnt == {1'b1, latCfg.wordLen});
  assign parOn    = latCfg.parityEn;

  always_comb begin
    unique case (ctl.drive)
      DRV_SPACE:  lineRaw = 1'b0;
      DRV_DATA:   lineRaw = shiftReg[0];
      DRV_PARITY: lineRaw = parBit;
      default:    lineRaw = 1'b1;
    endcase
  end

  assign txLine = breakCtl ? 1'b0 : lineRaw;

endmodule

// File: rtl/async_char_tx.sv
module async_char_tx
  import async_char_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic [7:0] wrData,
  input  logic       wrValid,
  input  logic [1:0] wordLen,
  input  logic       stopSel,
  input  logic       parityEn,
  input  logic       evenSel,
  input  logic       stickPar,
  input  logic       breakCtl,
  output logic       txLine,
  output logic       holdEmpty,
  output logic       txEmpty
);

  txCtrl_t   ctl;
  frameCfg_t cfgIn;
  logic      holdFull;
  logic      bitEnd;
  logic      lastData;
  logic      parOn;
  logic      shiftIdle;

  assign cfgIn = '{wordLen: wordLen, stopSel: stopSel, parityEn: parityEn,
                   evenSel: evenSel, stickPar: stickPar};

  async_char_tx_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .holdFull (holdFull),
    .bitEnd   (bitEnd),
    .lastData (lastData),
    .parOn    (parOn),
    .ctl      (ctl),
    .shiftIdle(shiftIdle)
  );

  async_char_tx_dp #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .baudTick(baudTick),
    .wrData  (wrData),
    .wrValid (wrValid),
    .cfgIn   (cfgIn),
    .breakCtl(breakCtl),
    .ctl     (ctl),
    .holdFull(holdFull),
    .bitEnd  (bitEnd),
    .lastData(lastData),
    .parOn   (parOn),
    .txLine  (txLine)
  );

  assign holdEmpty = !holdFull;
  assign txEmpty   = !holdFull && shiftIdle;

endmodule

// File: rtl/async_char_tx_chk.sv
module async_char_tx_chk (
  input logic clk,
  input logic rstN,
  input logic baudTick,
  input logic wrValid,
  input logic breakCtl,
  input logic txLine,
  input logic holdEmpty,
  input logic txEmpty
);

  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty && !breakCtl |-> txLine);

  assert_tick_paced_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txLine) && $stable(breakCtl) |-> $past(baudTick) || $rose(holdEmpty));

  assert_break_space_R7: assert property (@(posedge clk) disable iff (!rstN)
    breakCtl |-> !txLine);

  assert_write_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdEmpty) |-> $past(wrValid));

  assert_empty_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> holdEmpty);

  assert_start_on_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdEmpty) && !breakCtl |-> !txLine);

endmodule

bind async_char_tx async_char_tx_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .baudTick (baudTick),
  .wrValid  (wrValid),
  .breakCtl (breakCtl),
  .txLine   (txLine),
  .holdEmpty(holdEmpty),
  .txEmpty  (txEmpty)
);

// File: tb/async_char_tx_bench.sv
module async_char_tx_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TPB        = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       wrValid = 1'b0;
  logic [1:0] wordLen = 2'b11;
  logic       stopSel = 1'b0;
  logic       parityEn = 1'b0;
  logic       evenSel = 1'b0;
  logic       stickPar = 1'b0;
  logic       breakCtl = 1'b0;
  logic       txLine;
  logic       holdEmpty;
  logic       txEmpty;

  int    checks = 0;
  int    bad = 0;
  int    cycles = 0;
  int    tickDiv = 3;
  int    tickPh = 0;
  int    ticksInFrame = 0;
  int    emptySeen = 0;
  bit    modelOn = 0;
  string curReq = "R1";

  // reference model: a list of (level, remaining ticks) segments
  int   qLvl[$];
  int   qDur[$];
  bit   mHold = 0;
  logic [7:0] mHoldData = 8'h00;

  async_char_tx #(.TICKS_PER_BIT(TPB)) u_async_char_tx (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .wrData(wrData),
    .wrValid(wrValid), .wordLen(wordLen), .stopSel(stopSel),
    .parityEn(parityEn), .evenSel(evenSel), .stickPar(stickPar),
    .breakCtl(breakCtl), .txLine(txLine), .holdEmpty(holdEmpty),
    .txEmpty(txEmpty)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  task automatic check(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0d exp=%0d", req, what, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog expired during %s", curReq);
      summary();
    end
  end

  // tick generator, driven after the edge
  always @(posedge clk) begin
    #1;
    if (tickDiv <= 1) baudTick = 1'b1;
    else begin
      tickPh   = (tickPh + 1) % tickDiv;
      baudTick = (tickPh == 0);
    end
  end

  task automatic buildFrame(logic [7:0] d);
    int len;
    int ones;
    int par;
    len  = 5 + int'(wordLen);
    ones = 0;
    qLvl.push_back(0); qDur.push_back(TPB);
    for (int i = 0; i < len; i++) begin
      qLvl.push_back(int'(d[i])); qDur.push_back(TPB);
      ones += int'(d[i]);
    end
    if (parityEn) begin
      if (stickPar)     par = evenSel ? 0 : 1;
      else if (evenSel) par = ones % 2;
      else              par = 1 - (ones % 2);
      qLvl.push_back(par); qDur.push_back(TPB);
    end
    qLvl.push_back(1);
    if (!stopSel)           qDur.push_back(TPB);
    else if (wordLen == 0)  qDur.push_back(TPB + TPB / 2);
    else                    qDur.push_back(2 * TPB);
  endtask

  always @(posedge clk) begin
    bit busy;
    bit hn;
    bit fe;
    if (!rstN) begin
      qLvl.delete(); qDur.delete(); mHold = 0;
    end else begin
      busy = (qLvl.size() > 0);
      hn   = mHold;
      fe   = 0;
      if (busy && baudTick) begin
        qDur[0] = qDur[0] - 1;
        if (qDur[0] == 0) begin
          void'(qLvl.pop_front());
          void'(qDur.pop_front());
          fe = (qLvl.size() == 0);
        end
      end
      if (hn && (!busy || fe)) begin
        buildFrame(mHoldData);
        mHold = 0;
      end else if (wrValid && !hn) begin
        mHold     = 1;
        mHoldData = wrData;
      end
    end
  end

  // compare every cycle away from the edge
  always @(negedge clk) begin
    int expLine;
    if (rstN && modelOn) begin
      expLine = breakCtl ? 0 : ((qLvl.size() > 0) ? qLvl[0] : 1);
      check(curReq, "txLine", int'(txLine), expLine);
      check(curReq, "holdEmpty", int'(holdEmpty), int'(!mHold));
      check(curReq, "txEmpty", int'(txEmpty), int'(!mHold && qLvl.size() == 0));
      if (holdEmpty && !txEmpty && baudTick) ticksInFrame++;
      if (txEmpty) emptySeen++;
    end
  end

  task automatic writeChar(logic [7:0] d);
    @(posedge clk); #2;
    wrData  = d;
    wrValid = 1'b1;
    @(posedge clk); #2;
    wrValid = 1'b0;
  endtask

  task automatic waitIdle();
    int n;
    n = 0;
    do begin
      @(negedge clk); n++;
    end while (!txEmpty && n < 20000);
  endtask

  task automatic setCfg(logic [1:0] wl, logic st, logic pe, logic ev, logic sp);
    @(posedge clk); #2;
    wordLen = wl; stopSel = st; parityEn = pe; evenSel = ev; stickPar = sp;
  endtask

  task automatic frame(string req, logic [7:0] d);
    int expTicks;
    expTicks = TPB * (1 + 5 + int'(wordLen) + int'(parityEn));
    if (!stopSel)          expTicks += TPB;
    else if (wordLen == 0) expTicks += TPB + TPB / 2;
    else                   expTicks += 2 * TPB;
    curReq = req;
    ticksInFrame = 0;
    writeChar(d);
    waitIdle();
    check(req, "frame ticks", ticksInFrame, expTicks);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "reset txLine", int'(txLine), 1);
    check("R1", "reset holdEmpty", int'(holdEmpty), 1);
    check("R1", "reset txEmpty", int'(txEmpty), 1);
    modelOn = 1;

    // R2 basic 8-bit frame, bit order
    setCfg(2'b11, 0, 0, 0, 0);
    frame("R2", 8'hA5);
    frame("R2", 8'h01);

    // R3 each word length, high bits masked
    setCfg(2'b00, 0, 0, 0, 0); frame("R3", 8'hF3);
    setCfg(2'b01, 0, 0, 0, 0); frame("R3", 8'hD6);
    setCfg(2'b10, 0, 0, 0, 0); frame("R3", 8'hB9);

    // R4 stop lengths
    setCfg(2'b00, 1, 0, 0, 0); frame("R4", 8'h15);
    setCfg(2'b01, 1, 0, 0, 0); frame("R4", 8'h2A);
    setCfg(2'b11, 1, 0, 0, 0); frame("R4", 8'h7E);

    // R5 parity even and odd
    setCfg(2'b11, 0, 1, 1, 0); frame("R5", 8'h07);
    setCfg(2'b11, 0, 1, 0, 0); frame("R5", 8'h07);
    setCfg(2'b10, 0, 1, 1, 0); frame("R5", 8'hC3);

    // R6 stick parity both ways
    setCfg(2'b11, 0, 1, 1, 1); frame("R6", 8'hFF);
    setCfg(2'b11, 0, 1, 0, 1); frame("R6", 8'h00);

    // R7 break in the middle of a frame
    setCfg(2'b11, 0, 0, 0, 0);
    curReq = "R7";
    ticksInFrame = 0;
    writeChar(8'h5A);
    repeat (60) @(posedge clk);
    #2 breakCtl = 1'b1;
    @(negedge clk);
    check("R7", "line under break", int'(txLine), 0);
    repeat (50) @(posedge clk);
    #2 breakCtl = 1'b0;
    waitIdle();
    check("R7", "frame ticks under break", ticksInFrame, TPB * 10);

    // R8 writes while full are ignored
    curReq = "R8";
    writeChar(8'h11);
    @(negedge clk);
    check("R8", "holdEmpty after write", int'(holdEmpty), 0);
    writeChar(8'h22);
    writeChar(8'h33);
    waitIdle();

    // R9 flags while held and busy
    curReq = "R9";
    writeChar(8'h44);
    writeChar(8'h55);
    @(negedge clk);
    check("R9", "txEmpty while busy", int'(txEmpty), 0);
    waitIdle();

    // R10 back to back with a tick every cycle
    tickDiv = 1;
    curReq = "R10";
    writeChar(8'hC1);
    @(negedge clk);
    while (!holdEmpty) @(negedge clk);
    emptySeen = 0;
    writeChar(8'h3E);
    @(negedge clk);
    while (holdEmpty) @(negedge clk);
    while (!holdEmpty) @(negedge clk);
    check("R10", "idle cycles between frames", emptySeen, 0);
    waitIdle();
    tickDiv = 3;

    // R11 settings changed during a frame
    setCfg(2'b11, 0, 0, 0, 0);
    curReq = "R11";
    ticksInFrame = 0;
    writeChar(8'h96);
    repeat (40) @(posedge clk);
    #2 wordLen = 2'b00; stopSel = 1'b1; parityEn = 1'b1; evenSel = 1'b1;
    waitIdle();
    check("R11", "frame ticks kept", ticksInFrame, TPB * 10);

    repeat (5) @(posedge clk);
    summary();
  end

endmodule